// File: doc/BRIEF.md
# Pipelined Minimum-Cost Switching-State Selector

This block closes a finite-set predictive current controller for a two-level three-phase inverter. It takes eight candidate inverter states in one set. Each candidate is a cost value paired with the 3-bit switching pattern that produced it. The block returns the cost that is lowest and the pattern that belongs to it. The search is a linear chain of compare-and-select stages. A single select bit in each stage steers two multiplexers at once: one carries the running minimum cost and the other carries the pattern paired with it.

A register follows every stage, so a new candidate set can be accepted on every clock. The winning pattern is split into three gate commands for the upper transistors of phases A, B and C. These commands are held between results. The lower-leg gates and dead-time insertion are left to the inverter stage downstream.

Top module: `argsel_top`

## Requirements
- R1: For each accepted set, `min_cost` equals the smallest of the eight costs. Candidate j's cost sits at `cost_in[j*COST_W +: COST_W]`.
- R2: The gate outputs carry the pattern paired with the minimum cost. Candidate j's pattern sits at `pat_in[j*3 +: 3]`. Pattern bit 2 drives `gate_a`, bit 1 drives `gate_b` and bit 0 drives `gate_c`.
- R3: When several candidates share the minimum cost, the lowest index wins. If all eight costs are equal, candidate 0 is selected.
- R4: A set sampled with `in_valid` high at clock edge n produces exactly one `out_valid` pulse after edge n+7, which is eight edges counting edge n. No other `out_valid` pulses occur.
- R5: Sets may arrive on consecutive clocks. Their results come out one per clock, in arrival order, and each is correct.
- R6: `min_cost` and the gate outputs change only in a cycle where `out_valid` is high; otherwise they hold.
- R7: After reset, `out_valid` is 0, `min_cost` is 0 and the gate pattern is 0,0,0.
- R8: Cost and pattern inputs presented while `in_valid` is low are ignored: no result appears and the outputs keep their last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Marks a candidate set on the inputs |
| cost_in | input | N_CAND*COST_W | Packed candidate costs, candidate 0 in the low bits |
| pat_in | input | N_CAND*3 | Packed switching patterns, candidate 0 in the low bits |
| out_valid | output | 1 | One-cycle pulse marking a new result |
| min_cost | output | COST_W | Lowest cost of the set, held |
| gate_a | output | 1 | Phase A upper-switch command, held |
| gate_b | output | 1 | Phase B upper-switch command, held |
| gate_c | output | 1 | Phase C upper-switch command, held |

## Verification
A stage whose select bit drifts away from its cost multiplexer shows up as a pattern that no longer belongs to the reported minimum. This appears on the very result that passes through that stage, eight clocks after the set entered. A misaligned candidate delay line makes sets feed on their neighbours' candidates, so back-to-back streams with distinct costs show wrong minima at once. A wrong tie rule shows only on sets with equal costs, so these are driven explicitly. A broken hold or valid path shows as outputs that move with no pulse present, or as missing or extra pulses.

// File: rtl/argsel_pkg.sv
`timescale 1ns/1ps
package argsel_pkg;
  localparam int PHASES = 3;
  typedef logic [PHASES-1:0] sw_pat_t;
  typedef struct packed {
    logic a;
    logic b;
    logic c;
  } gate_t;
endpackage

// File: rtl/argsel_rst_sync.sv
`timescale 1ns/1ps
module argsel_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= '0;
    else          sync_q <= sync_d;
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/argsel_dly.sv
`timescale 1ns/1ps
// Candidate delay line: entry k advances only when the set it belongs to
// is valid at pipeline level k, so it stays aligned with the compare chain.
module argsel_dly #(
  parameter int W     = 19,
  parameter int DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DEPTH-1:0] en,
  input  logic [W-1:0]     d_i,
  output logic [W-1:0]     d_o
);
  logic [W-1:0] sr_q [0:DEPTH-1];

  for (genvar k = 0; k < DEPTH; k++) begin : g_tap
    logic [W-1:0] tap_d;
    if (k == 0) begin : g_head
      always_comb tap_d = d_i;
    end else begin : g_body
      always_comb tap_d = sr_q[k-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     sr_q[k] <= '0;
      else if (en[k]) sr_q[k] <= tap_d;
    end
  end

  assign d_o = sr_q[DEPTH-1];
endmodule

// File: rtl/argsel_stage.sv
`timescale 1ns/1ps
// One compare/select link: the select bit steers cost and pattern together.
module argsel_stage
  import argsel_pkg::*;
#(
  parameter int COST_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              v_i,
  input  logic [COST_W-1:0] run_cost_i,
  input  sw_pat_t           run_pat_i,
  input  logic [COST_W-1:0] cand_cost_i,
  input  sw_pat_t           cand_pat_i,
  output logic              v_o,
  output logic [COST_W-1:0] run_cost_o,
  output sw_pat_t           run_pat_o
);
  logic              take_cand;
  logic [COST_W-1:0] cost_d, cost_q;
  sw_pat_t           pat_d, pat_q;
  logic              v_q;

  // strict less-than keeps the earlier candidate on a tie
  always_comb begin
    take_cand = (cand_cost_i < run_cost_i);
    cost_d    = take_cand ? cand_cost_i : run_cost_i;
    pat_d     = take_cand ? cand_pat_i  : run_pat_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q    <= 1'b0;
      cost_q <= '0;
      pat_q  <= '0;
    end else begin
      v_q <= v_i;
      if (v_i) begin
        cost_q <= cost_d;
        pat_q  <= pat_d;
      end
    end
  end

  assign v_o        = v_q;
  assign run_cost_o = cost_q;
  assign run_pat_o  = pat_q;
endmodule

// File: rtl/argsel_hold.sv
`timescale 1ns/1ps
module argsel_hold
  import argsel_pkg::*;
#(
  parameter int COST_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              v_i,
  input  logic [COST_W-1:0] cost_i,
  input  sw_pat_t           pat_i,
  output logic              out_valid,
  output logic [COST_W-1:0] min_cost,
  output gate_t             gates
);
  logic              vld_d, vld_q;
  logic [COST_W-1:0] cost_d, cost_q;
  gate_t             gate_d, gate_q;

  always_comb begin
    vld_d  = v_i;
    cost_d = v_i ? cost_i : cost_q;
    gate_d = v_i ? gate_t'(pat_i) : gate_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      cost_q <= '0;
      gate_q <= '0;
    end else begin
      vld_q  <= vld_d;
      cost_q <= cost_d;
      gate_q <= gate_d;
    end
  end

  assign out_valid = vld_q;
  assign min_cost  = cost_q;
  assign gates     = gate_q;
endmodule

// File: rtl/argsel_top.sv
`timescale 1ns/1ps
module argsel_top
  import argsel_pkg::*;
#(
  parameter int N_CAND = 8,
  parameter int COST_W = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  input  logic [N_CAND*COST_W-1:0]   cost_in,
  input  logic [N_CAND*PHASES-1:0]   pat_in,
  output logic                       out_valid,
  output logic [COST_W-1:0]          min_cost,
  output logic                       gate_a,
  output logic                       gate_b,
  output logic                       gate_c
);
  localparam int CAND_W = COST_W + PHASES;

  logic                rst_sync_n;
  logic [N_CAND-1:0]   v_vec;
  logic [COST_W-1:0]   rc_p [0:N_CAND-1];
  sw_pat_t             rp_p [0:N_CAND-1];
  logic [CAND_W-1:0]   cand_at [1:N_CAND-1];
  gate_t               gates;

  argsel_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_sync_n)
  );

  // candidate 0 seeds the running minimum
  assign v_vec[0] = in_valid;
  assign rc_p[0]  = cost_in[0 +: COST_W];
  assign rp_p[0]  = pat_in[0 +: PHASES];

  for (genvar j = 1; j < N_CAND; j++) begin : g_cand
    if (j == 1) begin : g_direct
      assign cand_at[j] = {cost_in[j*COST_W +: COST_W], pat_in[j*PHASES +: PHASES]};
    end else begin : g_delayed
      argsel_dly #(.W(CAND_W), .DEPTH(j-1)) u_dly (
        .clk   (clk),
        .rst_n (rst_sync_n),
        .en    (v_vec[j-2:0]),
        .d_i   ({cost_in[j*COST_W +: COST_W], pat_in[j*PHASES +: PHASES]}),
        .d_o   (cand_at[j])
      );
    end
  end

  for (genvar s = 1; s < N_CAND; s++) begin : g_chain
    argsel_stage #(.COST_W(COST_W)) u_stage (
      .clk         (clk),
      .rst_n       (rst_sync_n),
      .v_i         (v_vec[s-1]),
      .run_cost_i  (rc_p[s-1]),
      .run_pat_i   (rp_p[s-1]),
      .cand_cost_i (cand_at[s][CAND_W-1:PHASES]),
      .cand_pat_i  (cand_at[s][PHASES-1:0]),
      .v_o         (v_vec[s]),
      .run_cost_o  (rc_p[s]),
      .run_pat_o   (rp_p[s])
    );
  end

  argsel_hold #(.COST_W(COST_W)) u_hold (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .v_i       (v_vec[N_CAND-1]),
    .cost_i    (rc_p[N_CAND-1]),
    .pat_i     (rp_p[N_CAND-1]),
    .out_valid (out_valid),
    .min_cost  (min_cost),
    .gates     (gates)
  );

  assign gate_a = gates.a;
  assign gate_b = gates.b;
  assign gate_c = gates.c;
endmodule

// File: rtl/argsel_chk.sv
`timescale 1ns/1ps
module argsel_chk #(
  parameter int N_CAND = 8,
  parameter int COST_W = 16
) (
  input logic                     clk,
  input logic                     rst_q,
  input logic                     in_valid,
  input logic [N_CAND*COST_W-1:0] cost_in,
  input logic [N_CAND*3-1:0]      pat_in,
  input logic                     out_valid,
  input logic [COST_W-1:0]        min_cost,
  input logic                     gate_a,
  input logic                     gate_b,
  input logic                     gate_c
);
  localparam int LAT = N_CAND;

  logic [COST_W-1:0] ref_m;
  logic [2:0]        ref_p;
  logic [LAT-1:0]    vpipe;
  logic [COST_W-1:0] mref [0:LAT-1];
  logic [2:0]        pref [0:LAT-1];

  always_comb begin
    ref_m = cost_in[0 +: COST_W];
    ref_p = pat_in[0 +: 3];
    for (int j = 1; j < N_CAND; j++) begin
      if (cost_in[j*COST_W +: COST_W] < ref_m) begin
        ref_m = cost_in[j*COST_W +: COST_W];
        ref_p = pat_in[j*3 +: 3];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      vpipe <= '0;
      for (int k = 0; k < LAT; k++) begin
        mref[k] <= '0;
        pref[k] <= '0;
      end
    end else begin
      vpipe   <= {vpipe[LAT-2:0], in_valid};
      mref[0] <= ref_m;
      pref[0] <= ref_p;
      for (int k = 1; k < LAT; k++) begin
        mref[k] <= mref[k-1];
        pref[k] <= pref[k-1];
      end
    end
  end

  // R4
  latency_pulse_chk: assert property (@(posedge clk) disable iff (!rst_q)
    out_valid == vpipe[LAT-1]);

  // R1
  min_value_chk: assert property (@(posedge clk) disable iff (!rst_q)
    out_valid |-> min_cost == mref[LAT-1]);

  // R2 (tie rule of R3 included in the reference)
  gate_pattern_chk: assert property (@(posedge clk) disable iff (!rst_q)
    out_valid |-> {gate_a, gate_b, gate_c} == pref[LAT-1]);

  // R6
  hold_outputs_chk: assert property (@(posedge clk) disable iff (!rst_q)
    !out_valid |-> $stable({gate_a, gate_b, gate_c, min_cost}));

  // R7
  reset_state_chk: assert property (@(posedge clk)
    $rose(rst_q) |-> (!out_valid && min_cost == '0 && {gate_a, gate_b, gate_c} == 3'b000));
endmodule

bind argsel_top argsel_chk #(.N_CAND(N_CAND), .COST_W(COST_W)) u_chk (
  .clk       (clk),
  .rst_q     (rst_sync_n),
  .in_valid  (in_valid),
  .cost_in   (cost_in),
  .pat_in    (pat_in),
  .out_valid (out_valid),
  .min_cost  (min_cost),
  .gate_a    (gate_a),
  .gate_b    (gate_b),
  .gate_c    (gate_c)
);

// File: tb/argsel_top_tb.sv
`timescale 1ns/1ps
module argsel_top_tb;
  localparam int N  = 8;
  localparam int CW = 16;
  localparam int PW = 3;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            in_valid;
  logic [N*CW-1:0] cost_in;
  logic [N*PW-1:0] pat_in;
  logic            out_valid;
  logic [CW-1:0]   min_cost;
  logic            gate_a, gate_b, gate_c;

  always #2 clk = ~clk;

  argsel_top #(.N_CAND(N), .COST_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .cost_in(cost_in),
    .pat_in(pat_in), .out_valid(out_valid), .min_cost(min_cost),
    .gate_a(gate_a), .gate_b(gate_b), .gate_c(gate_c)
  );

  typedef struct {
    logic [CW-1:0] c;
    logic [PW-1:0] p;
    int            cyc;
  } exp_t;

  exp_t          sb[$];
  int            n_chk = 0;
  int            n_fail = 0;
  int            pcnt = 0;
  bit            mon_on = 1'b0;
  logic [CW-1:0] cv [N];
  logic [PW-1:0] pv [N];
  logic [CW-1:0] lfsr = 16'hACE1;
  logic [CW+2:0] snap;

  always @(posedge clk) pcnt++;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic send();
    exp_t e;
    @(negedge clk);
    e.c = cv[0];
    e.p = pv[0];
    for (int j = 0; j < N; j++) begin
      cost_in[j*CW +: CW] = cv[j];
      pat_in[j*PW +: PW]  = pv[j];
      if (cv[j] < e.c) begin
        e.c = cv[j];
        e.p = pv[j];
      end
    end
    in_valid = 1'b1;
    e.cyc = pcnt;
    sb.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  task automatic step_lfsr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  // monitor: pops the scoreboard as results appear
  always @(negedge clk) begin
    exp_t e;
    if (mon_on) begin
      if (out_valid) begin
        if (sb.size() == 0) begin
          chk(1'b0, "R4", "pulse with nothing pending", 1, 0);
        end else begin
          e = sb.pop_front();
          chk(min_cost == e.c, "R1", "min_cost", min_cost, e.c);
          chk({gate_a, gate_b, gate_c} == e.p, "R2/R3", "gates", {gate_a, gate_b, gate_c}, e.p);
          chk(pcnt - e.cyc == 8, "R4", "latency", pcnt - e.cyc, 8);
        end
      end else if ({gate_a, gate_b, gate_c, min_cost} != snap) begin
        chk(1'b0, "R6", "outputs moved without pulse", {gate_a, gate_b, gate_c, min_cost}, snap);
      end
      snap = {gate_a, gate_b, gate_c, min_cost};
    end
  end

  initial begin
    #(200000 * 4);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; cost_in = '0; pat_in = '0;
    for (int j = 0; j < N; j++) pv[j] = PW'(j);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R7 reset state
    chk(out_valid == 1'b0, "R7", "out_valid", out_valid, 0);
    chk(min_cost == '0, "R7", "min_cost", min_cost, 0);
    chk({gate_a, gate_b, gate_c} == 3'b000, "R7", "gates", {gate_a, gate_b, gate_c}, 0);
    snap = {gate_a, gate_b, gate_c, min_cost};
    mon_on = 1'b1;

    // R1 R2: minimum in the middle, index 5 -> gates 1,0,1
    cv = '{16'd900, 16'd700, 16'd850, 16'd400, 16'd999, 16'd120, 16'd300, 16'd640};
    send(); idle(10);
    chk({gate_a, gate_b, gate_c} == 3'b101, "R2", "gate split of pattern 5", {gate_a, gate_b, gate_c}, 3'b101);
    // minimum first
    cv = '{16'd5, 16'd700, 16'd850, 16'd400, 16'd999, 16'd120, 16'd300, 16'd640};
    send(); idle(10);
    // minimum last
    cv = '{16'd900, 16'd700, 16'd850, 16'd400, 16'd999, 16'd120, 16'd300, 16'd7};
    send(); idle(10);
    // R3: tie at index 2 and 6 -> 2
    cv = '{16'd90, 16'd70, 16'd11, 16'd40, 16'd99, 16'd12, 16'd11, 16'd64};
    send(); idle(10);
    chk({gate_a, gate_b, gate_c} == 3'b010, "R3", "tie keeps lower index", {gate_a, gate_b, gate_c}, 3'b010);
    // R3: all equal, reversed patterns -> candidate 0 pattern 7
    for (int j = 0; j < N; j++) begin cv[j] = 16'd500; pv[j] = PW'(7 - j); end
    send(); idle(10);
    chk({gate_a, gate_b, gate_c} == 3'b111, "R3", "all equal picks candidate 0", {gate_a, gate_b, gate_c}, 3'b111);
    // extremes
    for (int j = 0; j < N; j++) cv[j] = 16'hFFFF;
    cv[3] = 16'hFFFE;
    send(); idle(10);
    for (int j = 0; j < N; j++) cv[j] = 16'h0000;
    send(); idle(10);

    // R5: back-to-back stream
    for (int i = 0; i < 12; i++) begin
      for (int j = 0; j < N; j++) begin step_lfsr(); cv[j] = lfsr; pv[j] = lfsr[2:0]; end
      send();
    end
    // bubbles between sets
    for (int i = 0; i < 6; i++) begin
      for (int j = 0; j < N; j++) begin step_lfsr(); cv[j] = lfsr >> (i % 4); pv[j] = lfsr[5:3]; end
      send(); idle(i % 3 + 1);
    end
    idle(12);
    chk(sb.size() == 0, "R5", "all streamed results returned", sb.size(), 0);

    // R8: garbage inputs with in_valid low are ignored
    snap = {gate_a, gate_b, gate_c, min_cost};
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      for (int j = 0; j < N; j++) begin step_lfsr(); cost_in[j*CW +: CW] = lfsr; pat_in[j*PW +: PW] = lfsr[2:0]; end
      in_valid = 1'b0;
    end
    idle(4);
    chk({gate_a, gate_b, gate_c, min_cost} == snap, "R8", "outputs after ignored inputs",
        {gate_a, gate_b, gate_c, min_cost}, snap);
    chk(sb.size() == 0, "R8", "no pending results", sb.size(), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule